// File: doc/BRIEF.md
# Boot Sector Map and Write Protection Guard

This block sits between the command decoder of a 256 KB byte-wide flash array and its program and erase machinery. It turns an 18-bit byte address into the index of the sector that holds it. The array uses a boot-block layout. Three 64 KB sectors make up most of the space. One end of the address range is split more finely, into a 32 KB sector, two 8 KB sectors and a 16 KB sector. A parameter chooses whether the fine-grained end sits at the bottom or at the top of the address space. The two layouts are mirror images of each other.

One protection bit is held per sector. A program attempt at the checked address is permitted only when that sector's protection bit is clear, or while the temporary unlock flag is high. The flag stands for the high-voltage condition on the reset pin. Clearing the flag does not change the stored bits, so every sector that was locked before is locked again at once. A multi-sector erase request arrives as a sector mask. The block returns that mask with the locked sectors removed, so an erase skips them and still completes. The stored bit for the addressed sector is also given to the identification read path. A load port writes all protection bits at once, standing in for the programming equipment.

Top module: `bootsect_guard`

## Requirements
- R1: With BOOT_TOP=0, sect_idx counts sectors upward from address 0: 0 = 00000h-03FFFh, 1 = 04000h-05FFFh, 2 = 06000h-07FFFh, 3 = 08000h-0FFFFh, 4 = 10000h-1FFFFh, 5 = 20000h-2FFFFh, 6 = 30000h-3FFFFh. Only address bits 17:13 affect it.
- R2: With BOOT_TOP=1 the layout is mirrored, still counting upward from address 0: 0 = 00000h-0FFFFh, 1 = 10000h-1FFFFh, 2 = 20000h-2FFFFh, 3 = 30000h-37FFFh, 4 = 38000h-39FFFh, 5 = 3A000h-3BFFFh, 6 = 3C000h-3FFFFh.
- R3: While temp_unlock is 0, prog_ok is 0 when bit sect_idx of the stored protection set is 1.
- R4: While temp_unlock is 1, prog_ok is 1 and erase_go equals erase_sel for every sector.
- R5: When temp_unlock returns to 0, every sector locked before is locked again, with no reload.
- R6: After reset all protection bits are 0: prog_ok is 1 and asel_prot is 0 at every address.
- R7: erase_go bit s is erase_sel bit s with every sector removed whose protection is in force, where bit s stands for sector index s.
- R8: A cycle with prot_load high replaces the whole protection set with prot_val (bit s = sector s). The new set is seen from the next clock edge on, and the set is otherwise held.
- R9: asel_prot gives the stored protection bit of the addressed sector and does not depend on temp_unlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prot_load | input | 1 | Load strobe for the protection set |
| prot_val | input | 7 | New protection set, bit s = sector s |
| temp_unlock | input | 1 | Temporary unlock flag |
| chk_addr | input | 18 | Byte address under check |
| erase_sel | input | 7 | Sectors requested for erase |
| sect_idx | output | 3 | Sector index of chk_addr |
| prog_ok | output | 1 | Program or erase at chk_addr is permitted |
| asel_prot | output | 1 | Stored protection bit of the addressed sector |
| erase_go | output | 7 | Sectors that will actually be erased |

## Verification
The address map is tried at the first and last byte of every sector, on a bottom-boot and a top-boot instance driven with the same address. This separates each boundary error from a mirroring error. The low address bits run from all zeros to all ones inside a sector, which shows that they have no effect. Protection is tried with a sparse mask, with the unlock flag raised and then cleared, and with an all-zero reload. This separates the stored bits from the protection that is in force, and erase masks show that only locked sectors are removed.

// File: rtl/bootsect_pkg.sv
package bootsect_pkg;
  localparam int SECT_N = 7;
  localparam int IDX_W  = $clog2(SECT_N);
  localparam int TAG_W  = 5;

  function automatic int sect_kb(input bit top, input int s);
    int k;
    k = top ? (SECT_N - 1 - s) : s;
    case (k)
      0: return 16;
      1, 2: return 8;
      3: return 32;
      default: return 64;
    endcase
  endfunction

  function automatic int sect_base_kb(input bit top, input int s);
    int b;
    b = 0;
    for (int i = 0; i < SECT_N; i++)
      if (i < s) b += sect_kb(top, i);
    return b;
  endfunction

  function automatic logic [IDX_W-1:0] low_boot_idx(input logic [TAG_W-1:0] t);
    if (t[4:3] != 2'b00) return IDX_W'(3 + int'(t[4:3]));
    else if (t[2])       return IDX_W'(3);
    else if (t[1])       return t[0] ? IDX_W'(2) : IDX_W'(1);
    else                 return IDX_W'(0);
  endfunction

  function automatic logic [IDX_W-1:0] map_idx(input bit top, input logic [TAG_W-1:0] t);
    if (top) return IDX_W'(SECT_N - 1) - low_boot_idx(~t);
    return low_boot_idx(t);
  endfunction
endpackage

// File: rtl/bootmap_decode.sv
module bootmap_decode
  import bootsect_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter bit BOOT_TOP = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic [SECT_N-1:0] hit
);
  localparam int TAG_LSB = ADDR_W - TAG_W;

  logic [31:0] addr32;
  assign addr32 = 32'(addr);
  assign idx = map_idx(BOOT_TOP, addr[ADDR_W-1:TAG_LSB]);

  for (genvar s = 0; s < SECT_N; s++) begin : g_range
    localparam int LO = sect_base_kb(BOOT_TOP, s) * 1024;
    localparam int HI = LO + sect_kb(BOOT_TOP, s) * 1024;
    assign hit[s] = (addr32 >= 32'(LO)) && (addr32 < 32'(HI));
  end

  AST_ONE_SECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(hit) == 1); // R1
  AST_IDX_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    hit[idx]); // R2
endmodule

// File: rtl/prot_bank.sv
module prot_bank
  import bootsect_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SECT_N-1:0] load_val,
  input  logic              unlock,
  output logic [SECT_N-1:0] stored,
  output logic [SECT_N-1:0] in_force
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    stored <= '0;
    else if (load) stored <= load_val;
  end

  assign in_force = unlock ? '0 : stored;

  AST_HOLD_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(stored)); // R8
  AST_LOAD_SET: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> stored == $past(load_val)); // R8
endmodule

// File: rtl/bootsect_guard.sv
module bootsect_guard
  import bootsect_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter bit BOOT_TOP = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prot_load,
  input  logic [SECT_N-1:0] prot_val,
  input  logic              temp_unlock,
  input  logic [ADDR_W-1:0] chk_addr,
  input  logic [SECT_N-1:0] erase_sel,
  output logic [IDX_W-1:0]  sect_idx,
  output logic              prog_ok,
  output logic              asel_prot,
  output logic [SECT_N-1:0] erase_go
);
  logic [SECT_N-1:0] sect_hit;
  logic [SECT_N-1:0] prot_stored;
  logic [SECT_N-1:0] prot_force;

  bootmap_decode #(.ADDR_W(ADDR_W), .BOOT_TOP(BOOT_TOP)) map_i (
    .clk(clk), .rst_n(rst_n), .addr(chk_addr), .idx(sect_idx), .hit(sect_hit));

  prot_bank bank_i (
    .clk(clk), .rst_n(rst_n), .load(prot_load), .load_val(prot_val),
    .unlock(temp_unlock), .stored(prot_stored), .in_force(prot_force));

  assign prog_ok   = ~|(prot_force & sect_hit);
  assign asel_prot = prot_stored[sect_idx];
  assign erase_go  = erase_sel & ~prot_force;

  AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!temp_unlock && prot_stored[sect_idx]) |-> !prog_ok); // R3
  AST_UNLOCK_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    temp_unlock |-> (prog_ok && erase_go == erase_sel)); // R4
  AST_ERASE_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_go & ~erase_sel) == '0); // R7
  AST_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(temp_unlock) && $stable(chk_addr) && asel_prot) |-> !prog_ok); // R5
endmodule

// File: tb/bootsect_guard_tb_top.sv
`timescale 1ns/1ps
module bootsect_guard_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prot_load = 1'b0;
  logic [6:0] prot_val = '0;
  logic temp_unlock = 1'b0;
  logic [17:0] chk_addr = '0;
  logic [6:0] erase_sel = '0;
  logic [2:0] idx_b, idx_t;
  logic ok_b, ok_t, as_b, as_t;
  logic [6:0] eg_b, eg_t;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  bootsect_guard #(.BOOT_TOP(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .prot_load(prot_load), .prot_val(prot_val),
    .temp_unlock(temp_unlock), .chk_addr(chk_addr), .erase_sel(erase_sel),
    .sect_idx(idx_b), .prog_ok(ok_b), .asel_prot(as_b), .erase_go(eg_b));

  bootsect_guard #(.BOOT_TOP(1'b1)) dut_top_i (
    .clk(clk), .rst_n(rst_n), .prot_load(prot_load), .prot_val(prot_val),
    .temp_unlock(temp_unlock), .chk_addr(chk_addr), .erase_sel(erase_sel),
    .sect_idx(idx_t), .prog_ok(ok_t), .asel_prot(as_t), .erase_go(eg_t));

  // {address, bottom-boot index, top-boot index}
  localparam logic [23:0] VEC [20] = '{
    {18'h00000, 3'd0, 3'd0}, {18'h03FFF, 3'd0, 3'd0},
    {18'h04000, 3'd1, 3'd0}, {18'h05FFF, 3'd1, 3'd0},
    {18'h06000, 3'd2, 3'd0}, {18'h07FFF, 3'd2, 3'd0},
    {18'h08000, 3'd3, 3'd0}, {18'h0FFFF, 3'd3, 3'd0},
    {18'h10000, 3'd4, 3'd1}, {18'h1FFFF, 3'd4, 3'd1},
    {18'h20000, 3'd5, 3'd2}, {18'h2FFFF, 3'd5, 3'd2},
    {18'h30000, 3'd6, 3'd3}, {18'h37FFF, 3'd6, 3'd3},
    {18'h38000, 3'd6, 3'd4}, {18'h39FFF, 3'd6, 3'd4},
    {18'h3A000, 3'd6, 3'd5}, {18'h3BFFF, 3'd6, 3'd5},
    {18'h3C000, 3'd6, 3'd6}, {18'h3FFFF, 3'd6, 3'd6}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic at_addr(input logic [17:0] a);
    @(negedge clk);
    chk_addr = a;
    #1;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R6: nothing locked after reset
    for (int i = 0; i < 20; i += 3) begin
      at_addr(VEC[i][23:6]);
      chk("R6 prog_ok", int'(ok_b), 1);
      chk("R6 asel_prot", int'(as_b), 0);
    end

    // R1 / R2: sector map at every boundary, both layouts
    foreach (VEC[i]) begin
      at_addr(VEC[i][23:6]);
      chk("R1 bottom idx", int'(idx_b), int'(VEC[i][5:3]));
      chk("R2 top idx", int'(idx_t), int'(VEC[i][2:0]));
    end

    // R8: load sectors 0,3,5
    @(negedge clk);
    prot_load = 1'b1; prot_val = 7'b0101001;
    chk_addr = 18'h00000;
    #1 chk("R8 not yet visible", int'(as_b), 0);
    @(negedge clk);
    prot_load = 1'b0; prot_val = 7'b1111111;
    #1 chk("R8 visible next edge", int'(as_b), 1);
    @(negedge clk) #1;
    chk("R8 held without strobe", int'(as_b), 1);

    // R3: locked and free sectors
    at_addr(18'h00000); chk("R3 bottom s0 locked", int'(ok_b), 0);
    at_addr(18'h08000); chk("R3 bottom s3 locked", int'(ok_b), 0);
    at_addr(18'h04000); chk("R3 bottom s1 free", int'(ok_b), 1);
    at_addr(18'h3C000); chk("R3 top s6 free", int'(ok_t), 1);
    at_addr(18'h00000); chk("R3 top s0 locked", int'(ok_t), 0);

    // R7: erase skips locked sectors
    @(negedge clk) erase_sel = 7'b1111111;
    #1 chk("R7 erase all", int'(eg_b), 7'b1010110);
    @(negedge clk) erase_sel = 7'b0011010;
    #1 chk("R7 erase subset", int'(eg_b), 7'b0010010);

    // R4 / R9: temporary unlock
    @(negedge clk) temp_unlock = 1'b1; erase_sel = 7'b1111111;
    #1;
    chk("R4 prog_ok unlocked", int'(ok_b), 1);
    chk("R4 erase all", int'(eg_b), 7'b1111111);
    chk("R9 asel under unlock", int'(as_b), 1);
    at_addr(18'h08000); chk("R4 s3 unlocked", int'(ok_b), 1);

    // R5: relock on clear
    @(negedge clk) temp_unlock = 1'b0;
    #1;
    chk("R5 s3 relocked", int'(ok_b), 0);
    chk("R5 erase relocked", int'(eg_b), 7'b1010110);

    // R8: reload with empty set
    @(negedge clk) prot_load = 1'b1; prot_val = 7'b0000000;
    @(negedge clk) prot_load = 1'b0;
    #1 chk("R8 reload clears", int'(ok_b), 1);
    chk("R8 reload erase", int'(eg_b), 7'b1111111);

    finish_run();
  end
endmodule